// File: doc/BRIEF.md
# Packed Multiply-Add-Shift Unit with Selectable Narrowing

This block is a SIMD datapath for eight packed signed 16-bit lanes. Each lane multiplies two operands, adds a third operand, shifts the sum right arithmetically by a shared amount, and reduces the result to 16 bits. One input picks how that reduction works. In cut mode the low bits are kept. In clamp mode the value is limited to the signed 16-bit range, and a per-lane flag reports each lane that had to be limited.

A typical use is fixed-point scaling. Setting the addend to 32767 and the shift to 16 gives a rounded high half of the product. Other addend and shift pairs give other rounding points and Q formats.

The unit has a fixed two-cycle pipeline with no back-pressure. A valid bit travels alongside the data, so the output valid repeats the input valid two clock edges later.

Top module: `pmar_unit`

## Requirements
- R1: For each lane, the value (A*B + C) is formed exactly from signed 16-bit A, B and C at 33-bit width, with no wrap before the shift. A lane whose A or B is zero and whose C is zero yields 0 with no flag.
- R2: The shift amount ranges over 0..31 and the shift is arithmetic, so negative values stay negative. For example, -1 shifted by 4 gives 16'hFFFF.
- R3: When sat_mode is 0 (cut mode), each lane outputs bits [15:0] of the shifted value, and every sat_flags bit is 0.
- R4: When sat_mode is 1 (clamp mode), a shifted value above 32767 outputs 16'h7FFF and a value below -32768 outputs 16'h8000. In either case the lane's sat_flags bit is 1.
- R5: When sat_mode is 1 and the shifted value lies within -32768..32767, the lane outputs that exact value and its flag is 0.
- R6: With C = 32767 and shift 16, the lane yields the rounded high half of the product. For example, 16'h8000 * 16'h8000 gives 16'h4000.
- R7: Results, flags and out_valid appear on the second rising edge after the inputs are sampled. out_valid equals in_valid from two edges earlier, including for back-to-back inputs.
- R8: Lanes are independent. Lane i uses bits [16i+15:16i] of every vector bus and drives sat_flags bit i.
- R9: While rst_n is low, and until the first input has moved through the pipeline, out_valid, res_vec and sat_flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the operand set as valid |
| a_vec | input | 128 | Packed multiplicand lanes |
| b_vec | input | 128 | Packed multiplier lanes |
| c_vec | input | 128 | Packed addend lanes |
| shift_amt | input | 5 | Arithmetic right-shift amount, shared by all lanes |
| sat_mode | input | 1 | 0 = cut to low bits, 1 = clamp to the signed range |
| out_valid | output | 1 | in_valid delayed by two cycles |
| res_vec | output | 128 | Packed 16-bit lane results |
| sat_flags | output | 8 | Per-lane clamp indicator |

## Verification
A corrupted first-stage sum, or a stale shift amount or mode bit held between the stages, surfaces two edges after the operands are presented. It appears as a wrong value in the affected lane or as a flag that disagrees with the clamp rule. A slipped valid bit shows up at once as out_valid out of step with the input pattern during back-to-back streaming. The sweep crosses every shift amount with both modes, using lane operands biased toward the extremes, and compares every lane against arithmetic done at 64-bit width. This catches an intermediate that is too narrow, a logical shift used in place of an arithmetic one, or a misplaced clamp boundary on the next result.

// File: rtl/pmar_pkg.sv
package pmar_pkg;
    localparam int LANE_W  = 16;
    localparam int PROD_W  = 2 * LANE_W;
    localparam int SUM_W   = PROD_W + 1;
    localparam int SHIFT_W = 5;

    typedef enum logic {
        NARROW_CUT   = 1'b0,
        NARROW_CLAMP = 1'b1
    } narrow_e;
endpackage

// File: rtl/pmar_mac_lane.sv
module pmar_mac_lane
    import pmar_pkg::*;
(
    input  logic signed [LANE_W-1:0] op_a,
    input  logic signed [LANE_W-1:0] op_b,
    input  logic signed [LANE_W-1:0] op_c,
    output logic signed [SUM_W-1:0]  sum
);
    localparam int PEXT = SUM_W - PROD_W;
    localparam int CEXT = SUM_W - LANE_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  prod_x;
    logic signed [SUM_W-1:0]  add_x;

    always_comb begin
        prod   = op_a * op_b;
        prod_x = {{PEXT{prod[PROD_W-1]}}, prod};
        add_x  = {{CEXT{op_c[LANE_W-1]}}, op_c};
        sum    = prod_x + add_x;
    end
endmodule

// File: rtl/pmar_narrow_lane.sv
module pmar_narrow_lane
    import pmar_pkg::*;
(
    input  logic signed [SUM_W-1:0]   sum,
    input  logic        [SHIFT_W-1:0] shamt,
    input  narrow_e                   mode,
    output logic        [LANE_W-1:0]  res,
    output logic                      sat
);
    localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

    logic signed [SUM_W-1:0]    shifted;
    logic [SUM_W-LANE_W:0]      upper;
    logic                       fits;

    always_comb begin
        shifted = sum >>> shamt;
        upper   = shifted[SUM_W-1:LANE_W-1];
        fits    = (&upper) | ~(|upper);
        res     = shifted[LANE_W-1:0];
        sat     = 1'b0;
        if (mode == NARROW_CLAMP && !fits) begin
            sat = 1'b1;
            res = shifted[SUM_W-1] ? NEG_LIM : POS_LIM;
        end
    end
endmodule

// File: rtl/pmar_unit.sv
module pmar_unit
    import pmar_pkg::*;
#(
    parameter int LANES = 8,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   a_vec,
    input  logic [VEC_W-1:0]   b_vec,
    input  logic [VEC_W-1:0]   c_vec,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic               sat_mode,
    output logic               out_valid,
    output logic [VEC_W-1:0]   res_vec,
    output logic [LANES-1:0]   sat_flags
);
    typedef struct packed {
        logic                              v1;
        logic [LANES-1:0][SUM_W-1:0]       sum1;
        logic [SHIFT_W-1:0]                sh1;
        narrow_e                           md1;
        logic                              v2;
        logic [LANES-1:0][LANE_W-1:0]      res2;
        logic [LANES-1:0]                  sat2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [LANES-1:0][SUM_W-1:0]  lane_sum;
    logic [LANES-1:0][LANE_W-1:0] lane_res;
    logic [LANES-1:0]             lane_sat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pmar_mac_lane u_mac (
            .op_a (a_vec[i*LANE_W +: LANE_W]),
            .op_b (b_vec[i*LANE_W +: LANE_W]),
            .op_c (c_vec[i*LANE_W +: LANE_W]),
            .sum  (lane_sum[i])
        );
        pmar_narrow_lane u_nar (
            .sum   (st_q.sum1[i]),
            .shamt (st_q.sh1),
            .mode  (st_q.md1),
            .res   (lane_res[i]),
            .sat   (lane_sat[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.v1   = in_valid;
        st_d.sum1 = lane_sum;
        st_d.sh1  = shift_amt;
        st_d.md1  = narrow_e'(sat_mode);
        st_d.v2   = st_q.v1;
        st_d.res2 = lane_res;
        st_d.sat2 = lane_sat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign res_vec   = st_q.res2;
    assign sat_flags = st_q.sat2;
endmodule

// File: rtl/pmar_chk.sv
module pmar_chk
    import pmar_pkg::*;
#(
    parameter int LANES = 8,
    localparam int VEC_W = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] a_vec,
    input logic [VEC_W-1:0] b_vec,
    input logic [VEC_W-1:0] c_vec,
    input logic             sat_mode,
    input logic             out_valid,
    input logic [VEC_W-1:0] res_vec,
    input logic [LANES-1:0] sat_flags
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end
    assign warm = (age_q == 2'd2);

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    // R3
    cut_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(sat_mode, 2)) |-> (sat_flags == '0));

    for (genvar i = 0; i < LANES; i++) begin : g_lchk
        // R4
        clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sat_flags[i] |-> (res_vec[i*LANE_W +: LANE_W] == 16'h7FFF ||
                              res_vec[i*LANE_W +: LANE_W] == 16'h8000));

        // R1
        zero_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && ($past(a_vec[i*LANE_W +: LANE_W], 2) == '0 ||
                      $past(b_vec[i*LANE_W +: LANE_W], 2) == '0) &&
                     $past(c_vec[i*LANE_W +: LANE_W], 2) == '0)
            |-> (res_vec[i*LANE_W +: LANE_W] == '0 && !sat_flags[i]));
    end
endmodule

bind pmar_unit pmar_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_vec     (a_vec),
    .b_vec     (b_vec),
    .c_vec     (c_vec),
    .sat_mode  (sat_mode),
    .out_valid (out_valid),
    .res_vec   (res_vec),
    .sat_flags (sat_flags)
);

// File: tb/pmar_unit_test.sv
`timescale 1ns/1ps
module pmar_unit_test;
    localparam int LN = 8;
    localparam int VW = LN * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] a_vec = '0, b_vec = '0, c_vec = '0;
    logic [4:0]    shift_amt = '0;
    logic          sat_mode = 1'b0;
    logic          out_valid;
    logic [VW-1:0] res_vec;
    logic [LN-1:0] sat_flags;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [15:0] ta [LN];
    logic [15:0] tb [LN];
    logic [15:0] tc [LN];

    always #10 clk = ~clk;

    pmar_unit #(.LANES(LN)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_vec(a_vec), .b_vec(b_vec), .c_vec(c_vec),
        .shift_amt(shift_amt), .sat_mode(sat_mode),
        .out_valid(out_valid), .res_vec(res_vec), .sat_flags(sat_flags)
    );

    function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                  input logic [15:0] c, input int r, input bit m,
                                  output logic [15:0] y, output bit f);
        longint s;
        s = longint'($signed(a)) * longint'($signed(b)) + longint'($signed(c));
        s = s >>> r;
        f = 1'b0;
        y = s[15:0];
        if (m) begin
            if (s > 32767)       begin y = 16'h7FFF; f = 1'b1; end
            else if (s < -32768) begin y = 16'h8000; f = 1'b1; end
        end
    endfunction

    function automatic logic [15:0] pick();
        case ($urandom_range(0, 7))
            0: return 16'h7FFF;
            1: return 16'h8000;
            2: return 16'hFFFF;
            3: return 16'h0001;
            4: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic load_bus();
        for (int i = 0; i < LN; i++) begin
            a_vec[i*16 +: 16] = ta[i];
            b_vec[i*16 +: 16] = tb[i];
            c_vec[i*16 +: 16] = tc[i];
        end
    endtask

    // Drive at a falling edge, wait two rising edges, sample at the next falling edge.
    task automatic run_vec(input int r, input bit m, input string req);
        logic [15:0] y;
        bit          f;
        bit          bad = 0;
        @(negedge clk);
        load_bus();
        shift_amt = 5'(r);
        sat_mode  = m;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1) bad = 1;
        for (int i = 0; i < LN; i++) begin
            model(ta[i], tb[i], tc[i], r, m, y, f);
            if (res_vec[i*16 +: 16] !== y || sat_flags[i] !== f) begin
                bad = 1;
                $display("FAIL %s lane %0d r=%0d m=%0d actual %h/%b expected %h/%b",
                         req, i, r, m, res_vec[i*16 +: 16], sat_flags[i], y, f);
            end
        end
        if (bad) begin
            errors++;
            if (out_valid !== 1'b1)
                $display("FAIL %s out_valid actual %b expected 1", req, out_valid);
        end
    endtask

    task automatic expect_lit(input int lane, input logic [15:0] exp_y,
                              input bit exp_f, input string req);
        checks++;
        if (res_vec[lane*16 +: 16] !== exp_y || sat_flags[lane] !== exp_f) begin
            errors++;
            $display("FAIL %s lane %0d actual %h/%b expected %h/%b", req, lane,
                     res_vec[lane*16 +: 16], sat_flags[lane], exp_y, exp_f);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        checks++;
        if (out_valid !== 1'b0 || res_vec !== '0 || sat_flags !== '0) begin
            errors++;
            $display("FAIL R9 actual %b/%h/%h expected 0/0/0", out_valid, res_vec, sat_flags);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || sat_flags !== '0) begin
            errors++;
            $display("FAIL R9 after release actual %b/%h expected 0/0", out_valid, sat_flags);
        end

        // R6: rounded high half, literal expectations
        for (int i = 0; i < LN; i++) begin
            ta[i] = (i % 2) ? 16'h4000 : 16'h8000;
            tb[i] = (i % 2) ? 16'h4000 : 16'h8000;
            tc[i] = 16'h7FFF;
        end
        run_vec(16, 1'b1, "R6");
        expect_lit(0, 16'h4000, 1'b0, "R6");
        expect_lit(1, 16'h1000, 1'b0, "R6");

        // R2: arithmetic shift keeps the sign
        for (int i = 0; i < LN; i++) begin
            ta[i] = 16'h0001; tb[i] = 16'hFFFF; tc[i] = 16'h0000;
        end
        run_vec(4, 1'b0, "R2");
        expect_lit(5, 16'hFFFF, 1'b0, "R2");

        // R1: 33-bit intermediate, largest product unshifted wraps only in cut mode
        for (int i = 0; i < LN; i++) begin
            ta[i] = 16'h8000; tb[i] = 16'h8000; tc[i] = 16'h7FFF;
        end
        run_vec(31, 1'b1, "R1");
        expect_lit(2, 16'h0000, 1'b0, "R1");
        run_vec(0, 1'b0, "R3");
        expect_lit(2, 16'h7FFF, 1'b0, "R3");
        run_vec(0, 1'b1, "R4");
        expect_lit(2, 16'h7FFF, 1'b1, "R4");

        // R8: only lane 3 overflows (negative), others in range
        for (int i = 0; i < LN; i++) begin
            ta[i] = 16'(i + 1); tb[i] = 16'h0003; tc[i] = 16'h0000;
        end
        ta[3] = 16'h7FFF; tb[3] = 16'h8000;
        run_vec(0, 1'b1, "R8");
        checks++;
        if (sat_flags !== 8'b0000_1000) begin
            errors++;
            $display("FAIL R8 flags actual %b expected 00001000", sat_flags);
        end
        expect_lit(3, 16'h8000, 1'b1, "R8");
        expect_lit(4, 16'h000F, 1'b0, "R5");

        // R1 R3 R4 R5: sweep every shift in both modes
        for (int r = 0; r < 32; r++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 30; k++) begin
                    for (int i = 0; i < LN; i++) begin
                        ta[i] = pick(); tb[i] = pick(); tc[i] = pick();
                    end
                    run_vec(r, m[0], m[0] ? "R4/R5" : "R1/R3");
                end
            end
        end

        // R7: back-to-back stream with a valid pattern
        begin
            logic [15:0] pat = 16'b1011_0010_1110_0101;
            logic [15:0] eres [18];
            bit          ev   [18];
            logic [15:0] y;
            bit          f;
            for (int k = 0; k < 18; k++) begin
                @(negedge clk);
                if (k >= 2) begin
                    checks++;
                    if (out_valid !== ev[k-2] ||
                        (ev[k-2] && res_vec[15:0] !== eres[k-2])) begin
                        errors++;
                        $display("FAIL R7 step %0d actual %b/%h expected %b/%h", k,
                                 out_valid, res_vec[15:0], ev[k-2], eres[k-2]);
                    end
                end
                if (k < 16) begin
                    for (int i = 0; i < LN; i++) begin
                        ta[i] = 16'($urandom); tb[i] = 16'($urandom); tc[i] = 16'(k);
                    end
                    load_bus();
                    shift_amt = 5'(k);
                    sat_mode  = k[0];
                    in_valid  = pat[k];
                    model(ta[0], tb[0], tc[0], k, k[0], y, f);
                    eres[k] = y;
                    ev[k]   = pat[k];
                end else begin
                    in_valid = 1'b0;
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule